// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the SCL waveform for an I2C master. It derives the low phase and the high phase of each SCL period from a programmable divider, and it supports standard mode (equal halves) and fast mode. Fast mode has two duty ratios: low twice as long as high, or a 16:9 low:high split. While enabled, the block runs SCL periods back to back. It drives SCL low during the low phase and releases it for the high phase. It also gives the byte engine a single-cycle tick at the start of each low phase and a second tick at the start of each counted high phase.

After SCL is released, the high-phase count does not begin at once. A programmable rise-time guard has to elapse first, and then the sampled SCL line has to read high. This keeps the high time measured from the point where the bus is actually high, whatever the pull-up strength. The same rule lets a slave stretch the clock, because a line held low stops the period from advancing. Configuration is expected to be held stable while the generator is enabled.

Top module: `scl_clk_gen`

## Requirements
- R1: While rst_ni is low or en_i is low, scl_low_o, lo_tick_o and hi_tick_o are all 0.
- R2: With fast_i = 0 (standard mode, duty_i ignored), the low phase and the high count each last D cycles, where D is div_i. The first low cycle is the cycle after the edge that samples en_i high.
- R3: With fast_i = 1 and duty_i = 0, the high count lasts D cycles and the low phase lasts 2·D cycles.
- R4: With fast_i = 1 and duty_i = 1, the high count lasts 9·D cycles and the low phase lasts 16·D cycles.
- R5: After SCL is released, the block waits until rise_i cycles have passed and until scl_i is then sampled high. The high count starts in the cycle after that sample. The released time is therefore max(rise_i, cycles scl_i stays low) + 1 + high count.
- R6: A divider below 4 in standard mode is used as 4. A divider of 0 in fast mode is used as 1. The low phase therefore always lasts at least 2 cycles.
- R7: While scl_i stays low after release (slave stretching), no high count begins and scl_low_o stays 0.
- R8: A clock edge that samples en_i low returns the block to idle with SCL released, from any phase.
- R9: lo_tick_o is 1 only in the first cycle of each low phase, and hi_tick_o is 1 only in the first cycle of each high count. Each tick is a single-cycle pulse. hi_tick_o is only raised after scl_i was sampled high on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run SCL periods while high |
| div_i | input | DIV_W | Divider value D |
| fast_i | input | 1 | 1 selects fast mode |
| duty_i | input | 1 | In fast mode, 1 selects the 16:9 low:high split |
| rise_i | input | RISE_W | Rise-time guard in cycles |
| scl_i | input | 1 | Synchronised SCL line level |
| scl_low_o | output | 1 | 1 drives SCL low |
| lo_tick_o | output | 1 | First cycle of a low phase |
| hi_tick_o | output | 1 | First cycle of a counted high phase |

## Verification
The bench builds the block with the default DIV_W = 12 and RISE_W = 6. With these widths it can use divider values of 0 to 10 and guards of 0 to 20, which covers both clamp boundaries, a single-cycle fast high phase, and a guard longer than the high phase. The bench holds SCL low by force in the middle of a period to exercise stretching. It also drops the enable during a running phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_RISE = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;
endpackage

// File: rtl/scl_phase_calc.sv
module scl_phase_calc #(
  parameter int DIV_W   = 12,
  parameter int STD_MIN = 4,
  localparam int CNT_W  = DIV_W + 4
) (
  input  logic [DIV_W-1:0] div_i,
  input  logic             fast_i,
  input  logic             duty_i,
  output logic [CNT_W-1:0] low_len_o,
  output logic [CNT_W-1:0] high_len_o
);
  logic [CNT_W-1:0] div_ext, base;

  assign div_ext = {4'b0, div_i};

  // clamp to the smallest legal divider of the selected mode (R6)
  always_comb begin
    if (!fast_i) base = (div_ext < CNT_W'(STD_MIN)) ? CNT_W'(STD_MIN) : div_ext;
    else         base = (div_ext == '0) ? CNT_W'(1) : div_ext;
  end

  always_comb begin
    if (!fast_i) begin
      low_len_o  = base;
      high_len_o = base;
    end else if (!duty_i) begin
      low_len_o  = base << 1;
      high_len_o = base;
    end else begin
      low_len_o  = base << 4;
      high_len_o = (base << 3) + base;
    end
  end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int RISE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              scl_i,
  input  logic [CNT_W-1:0]  low_len_i,
  input  logic [CNT_W-1:0]  high_len_i,
  input  logic [RISE_W-1:0] rise_i,
  output logic              scl_low_o,
  output logic              lo_tick_o,
  output logic              hi_tick_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rise_ext;
  logic             guard_done;

  assign rise_ext   = {{(CNT_W-RISE_W){1'b0}}, rise_i};
  assign guard_done = cnt_q >= rise_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (!en_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_q <= PH_LOW;
          cnt_q   <= '0;
        end
        PH_LOW: begin
          if (cnt_q == low_len_i - 1'b1) begin
            phase_q <= PH_RISE;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_RISE: begin
          // guard first, then wait for the line to read high (stretching)
          if (guard_done && scl_i) begin
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
          end else if (!guard_done) cnt_q <= cnt_q + 1'b1;
        end
        PH_HIGH: begin
          if (cnt_q == high_len_i - 1'b1) begin
            phase_q <= PH_LOW;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign scl_low_o = (phase_q == PH_LOW);
  assign lo_tick_o = (phase_q == PH_LOW)  && (cnt_q == '0);
  assign hi_tick_o = (phase_q == PH_HIGH) && (cnt_q == '0);
endmodule

// File: rtl/scl_clk_gen.sv
module scl_clk_gen #(
  parameter int DIV_W  = 12,
  parameter int RISE_W = 6,
  localparam int CNT_W = DIV_W + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              fast_i,
  input  logic              duty_i,
  input  logic [RISE_W-1:0] rise_i,
  input  logic              scl_i,
  output logic              scl_low_o,
  output logic              lo_tick_o,
  output logic              hi_tick_o
);
  logic [CNT_W-1:0] low_len, high_len;

  scl_phase_calc #(.DIV_W(DIV_W)) u_calc (
    .div_i      (div_i),
    .fast_i     (fast_i),
    .duty_i     (duty_i),
    .low_len_o  (low_len),
    .high_len_o (high_len)
  );

  scl_phase_fsm #(.CNT_W(CNT_W), .RISE_W(RISE_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .scl_i      (scl_i),
    .low_len_i  (low_len),
    .high_len_i (high_len),
    .rise_i     (rise_i),
    .scl_low_o  (scl_low_o),
    .lo_tick_o  (lo_tick_o),
    .hi_tick_o  (hi_tick_o)
  );
endmodule

// File: rtl/scl_clk_gen_chk.sv
module scl_clk_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic scl_i,
  input logic scl_low_o,
  input logic lo_tick_o,
  input logic hi_tick_o
);
  assert_idle_when_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!scl_low_o && !lo_tick_o && !hi_tick_o));

  assert_lo_tick_in_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_tick_o |-> scl_low_o);

  assert_hi_tick_released_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_tick_o |-> !scl_low_o);

  assert_low_start_ticks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_low_o) |-> lo_tick_o);

  assert_hi_after_line_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_tick_o |-> $past(scl_i));

  assert_min_low_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_tick_o && en_i) |=> (scl_low_o && !lo_tick_o));

  assert_hi_tick_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_tick_o |=> !hi_tick_o);
endmodule

bind scl_clk_gen scl_clk_gen_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .scl_i     (scl_i),
  .scl_low_o (scl_low_o),
  .lo_tick_o (lo_tick_o),
  .hi_tick_o (hi_tick_o)
);

// File: tb/scl_clk_gen_test.sv
module scl_clk_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W  = 12;
  localparam int RISE_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic fast = 1'b0, duty = 1'b0, stretch = 1'b0;
  logic [RISE_W-1:0] rise = '0;
  logic scl_low, lo_tick, hi_tick, scl_line;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // reference model: 0 idle, 1 low, 2 waiting release, 3 high
  int m_mode = 0, m_left = 0, m_rwait = 0;

  assign scl_line = ~(scl_low | stretch);

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_clk_gen #(.DIV_W(DIV_W), .RISE_W(RISE_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .div_i(div), .fast_i(fast),
    .duty_i(duty), .rise_i(rise), .scl_i(scl_line),
    .scl_low_o(scl_low), .lo_tick_o(lo_tick), .hi_tick_o(hi_tick)
  );

  function automatic int base_of();
    int d = int'(div);
    if (!fast) return (d < 4) ? 4 : d;
    return (d == 0) ? 1 : d;
  endfunction

  function automatic int want_low();
    if (!fast) return base_of();
    return duty ? 16 * base_of() : 2 * base_of();
  endfunction

  function automatic int want_high();
    if (!fast) return base_of();
    return duty ? 9 * base_of() : base_of();
  endfunction

  always @(posedge clk) begin
    if (!rst_n || !en) begin
      m_mode = 0;
    end else begin
      case (m_mode)
        0: begin m_mode = 1; m_left = want_low(); end
        1: if (m_left == 1) begin m_mode = 2; m_rwait = int'(rise); end
           else m_left--;
        2: if (m_rwait == 0 && scl_line) begin m_mode = 3; m_left = want_high(); end
           else if (m_rwait > 0) m_rwait--;
        default: if (m_left == 1) begin m_mode = 1; m_left = want_low(); end
                 else m_left--;
      endcase
    end
  end

  always @(negedge clk) begin
    logic e_low, e_lt, e_ht;
    if (!done) begin
      e_low = (m_mode == 1);
      e_lt  = (m_mode == 1) && (m_left == want_low());
      e_ht  = (m_mode == 3) && (m_left == want_high());
      checks++;
      if ({scl_low, lo_tick, hi_tick} !== {e_low, e_lt, e_ht}) begin
        fails++;
        $display("FAIL %s at %0t: low/lo_tick/hi_tick actual %b%b%b expected %b%b%b",
                 cur_req, $time, scl_low, lo_tick, hi_tick, e_low, e_lt, e_ht);
      end
    end
  end

  task automatic run(input string tag, input int d, input bit f, input bit du,
                     input int r, input int cycles);
    @(negedge clk);
    cur_req = "R8";
    en = 1'b0;
    repeat (3) @(negedge clk);
    cur_req = tag;
    div = DIV_W'(d); fast = f; duty = du; rise = RISE_W'(r);
    en = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset, then idle with enable low
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R2: standard 10, R9 ticks checked each cycle
    run("R2", 10, 1'b0, 1'b0, 3, 120);
    // R2: duty ignored in standard mode
    run("R2_duty", 7, 1'b0, 1'b1, 1, 80);
    // R3: fast duty 0
    run("R3", 5, 1'b1, 1'b0, 2, 90);
    // R4: fast duty 1
    run("R4", 1, 1'b1, 1'b1, 0, 150);
    // R6: clamps
    run("R6_std", 2, 1'b0, 1'b0, 0, 60);
    run("R6_fast", 0, 1'b1, 1'b0, 0, 40);
    // R5: guard longer than the high phase
    run("R5", 4, 1'b0, 1'b0, 20, 120);
    // R7: slave stretching during release
    run("R7", 6, 1'b0, 1'b0, 1, 13);
    stretch = 1'b1;
    repeat (25) @(negedge clk);
    stretch = 1'b0;
    repeat (60) @(negedge clk);
    // R8: drop enable inside a low phase
    run("R8_mid", 8, 1'b1, 1'b0, 2, 5);
    cur_req = "R8";
    en = 1'b0;
    repeat (6) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule